// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Capture

This block is a memory-mapped general-purpose I/O controller. Its pin count is set by a parameter and must be a multiple of 32. The defaults give 64 pins, and 96 pins is also supported. Pins are grouped into banks of 32. Every register group takes one 32-bit word per bank. The alternate-function group is the exception: it takes two words per bank, because it holds two bits per pin.

Software drives the pins through a single-cycle word bus. The controls are:
- a direction word per bank;
- write-one set words and write-one clear words for the output latch;
- rising-edge enable words and falling-edge enable words.

Reading the level group returns the synchronised pad state. Enabled transitions are captured in a sticky status word that software clears by writing ones to it. The OR of all status bits drives a single interrupt line. The 2-bit alternate-function code of each pin is exported for the pad ring to use.

A register word has word index `group * BANKS + bank` and byte address four times that index. The groups, in address order, are:

| Index | Group |
|---|---|
| 0 | level |
| 1 | direction |
| 2 | set |
| 3 | clear |
| 4 | rising enable |
| 5 | falling enable |
| 6 | status |
| 7 | alternate function, taking 2*BANKS words |

Top module: `gpio_bank_ctrl`

## Requirements
- R1: A bus access at byte address A selects word A/4, which is decoded as group (A/4)/BANKS and bank (A/4)%BANKS. A word index of 9*BANKS or above, or an address with A[1:0] not zero, reads as 0 and ignores writes. Writes to the level group are also ignored.
- R2: Writing a word to the set group (group 2) forces to 1 the output latch bits where the data is 1. Bits written as 0 keep their value. `pad_out` shows the latch on the clock edge after the write.
- R3: Writing a word to the clear group (group 3) forces to 0 the latch bits where the data is 1. Bits written as 0 keep their value.
- R4: The direction group (group 1) is read/write. A 1 in bit p drives `pad_oe[p]` high, making pin p an output, on the edge after the write.
- R5: Reading the level group (group 0) returns `pad_in` through a two-stage synchroniser. A value applied before clock edge k is read back after edge k+1.
- R6: When pin p's bit is set in the rising enable group (group 4), a 0-to-1 change of the synchronised pin sets status bit p. The bit is set on the edge after the change becomes visible in the level group.
- R7: When pin p's bit is set in the falling enable group (group 5), a 1-to-0 change sets status bit p in the same way. With both enables set, both kinds of change are captured.
- R8: Status bits (group 6) stay set until a bus write puts a 1 in their position. Writing all ones clears the whole word.
- R9: If an edge event and a write-one-clear reach the same status bit on the same clock edge, the bit ends up set.
- R10: `irq` is high exactly when at least one status bit is set.
- R11: The alternate-function group starts at word 7*BANKS and spans 2*BANKS words. Pin p's code sits in word 7*BANKS + p/16, bits [2*(p%16)+1 : 2*(p%16)]. These words are read/write, and `alt_func[2p+1:2p]` carries the code.
- R12: After reset, every latch, direction, enable, status and alternate-function bit is 0. The set and clear groups always read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released inside the block after two clock edges |
| bus_sel | input | 1 | Bus access strobe for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as a read strobe |
| pad_in | input | NUM_PINS | Pin levels, may be asynchronous |
| pad_out | output | NUM_PINS | Output latch |
| pad_oe | output | NUM_PINS | Output enable per pin |
| alt_func | output | 2*NUM_PINS | Alternate-function code, 2 bits per pin |
| irq | output | 1 | OR of all edge status bits |

## Verification
The checker assumes the bus inputs are stable around each rising clock edge and that addresses are word aligned. It ignores the first few edges after reset, while the internal reset release is still in progress. The stimulus follows the same rules: it changes bus signals and pads only on the falling edge, and it waits out the reset release before the first access. The sticky-interrupt property assumes that only a bus write to a status word can lower `irq`. The bench therefore mixes status writes into random traffic, so that clears often meet new edges on the same cycle.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int WORD_W = 32;
  localparam int GROUPS = 8;
  localparam int IDX_W  = 4;

  typedef enum logic [2:0] {
    GRP_LEVEL = 3'd0,
    GRP_DIR   = 3'd1,
    GRP_SET   = 3'd2,
    GRP_CLR   = 3'd3,
    GRP_RISE  = 3'd4,
    GRP_FALL  = 3'd5,
    GRP_STAT  = 3'd6,
    GRP_ALT   = 3'd7
  } grp_e;

  typedef struct packed {
    logic             hit;
    grp_e             grp;
    logic [IDX_W-1:0] idx;
  } dec_t;
endpackage

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
  import gpio_bank_pkg::*;
#(
  parameter int NBANK  = 2,
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output dec_t              dec
);
  localparam int WA_W      = ADDR_W - 2;
  localparam int ALT_BASE  = (GROUPS - 1) * NBANK;
  localparam int ALT_WORDS = 2 * NBANK;

  logic [WA_W-1:0] word;
  logic            aligned;

  assign word    = addr[ADDR_W-1:2];
  assign aligned = (addr[1:0] == 2'b00);

  always_comb begin
    dec = '{hit: 1'b0, grp: GRP_LEVEL, idx: '0};
    if (aligned) begin
      for (int g = 0; g < GROUPS - 1; g++) begin
        if (int'(word) >= g * NBANK && int'(word) < (g + 1) * NBANK) begin
          dec.hit = 1'b1;
          dec.grp = grp_e'(g[2:0]);
          dec.idx = IDX_W'(int'(word) - g * NBANK);
        end
      end
      if (int'(word) >= ALT_BASE && int'(word) < ALT_BASE + ALT_WORDS) begin
        dec.hit = 1'b1;
        dec.grp = GRP_ALT;
        dec.idx = IDX_W'(int'(word) - ALT_BASE);
      end
    end
  end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int NP = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NP-1:0] pad_in,
  output logic [NP-1:0] level,
  output logic [NP-1:0] rise,
  output logic [NP-1:0] fall
);
  logic [NP-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pad_in;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign level = sync_q;
  assign rise  = sync_q & ~prev_q;
  assign fall  = ~sync_q & prev_q;
endmodule

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] rise,
  input  logic [W-1:0] fall,
  input  logic [W-1:0] rise_en,
  input  logic [W-1:0] fall_en,
  input  logic [W-1:0] w1c,
  output logic [W-1:0] status
);
  logic [W-1:0] event_v, sts_d, sts_q;
  logic         sts_en;

  always_comb begin
    event_v = (rise & rise_en) | (fall & fall_en);
    // a fresh event wins over a clear on the same edge
    sts_d   = (sts_q & ~w1c) | event_v;
    sts_en  = (|w1c) | (|event_v);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sts_q <= '0;
    else if (sts_en) sts_q <= sts_d;
  end

  assign status = sts_q;
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS = 64,
  parameter int ADDR_W   = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_sel,
  input  logic                  bus_wr,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [31:0]           bus_wdata,
  output logic [31:0]           bus_rdata,
  input  logic [NUM_PINS-1:0]   pad_in,
  output logic [NUM_PINS-1:0]   pad_out,
  output logic [NUM_PINS-1:0]   pad_oe,
  output logic [2*NUM_PINS-1:0] alt_func,
  output logic                  irq
);
  localparam int NBANK     = NUM_PINS / WORD_W;
  localparam int ALT_WORDS = 2 * NBANK;

  // reset: asserted asynchronously, released after two edges
  logic [1:0] rsync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_core_n = rsync_q[1];

  dec_t dec;
  gpio_addr_dec #(.NBANK(NBANK), .ADDR_W(ADDR_W)) u_dec (
    .addr (bus_addr),
    .dec  (dec)
  );

  logic [NUM_PINS-1:0] level, rise, fall, status;
  gpio_in_sync #(.NP(NUM_PINS)) u_sync (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .pad_in (pad_in),
    .level  (level),
    .rise   (rise),
    .fall   (fall)
  );

  logic [NUM_PINS-1:0]   lat_q, lat_d, dir_q, dir_d;
  logic [NUM_PINS-1:0]   ren_q, ren_d, fen_q, fen_d, w1c;
  logic [2*NUM_PINS-1:0] alt_q, alt_d;
  logic                  wr_hit, rd_hit;
  logic                  lat_en, dir_en, ren_en, fen_en, alt_en;

  assign wr_hit = bus_sel & bus_wr & dec.hit;
  assign rd_hit = bus_sel & ~bus_wr & dec.hit;

  always_comb begin
    lat_en = wr_hit && (dec.grp == GRP_SET || dec.grp == GRP_CLR);
    dir_en = wr_hit && (dec.grp == GRP_DIR);
    ren_en = wr_hit && (dec.grp == GRP_RISE);
    fen_en = wr_hit && (dec.grp == GRP_FALL);
    alt_en = wr_hit && (dec.grp == GRP_ALT);
  end

  // next-state for software-written state
  always_comb begin
    lat_d = lat_q;
    dir_d = dir_q;
    ren_d = ren_q;
    fen_d = fen_q;
    alt_d = alt_q;
    w1c   = '0;
    if (wr_hit) begin
      for (int b = 0; b < NBANK; b++) begin
        if (dec.idx == IDX_W'(b)) begin
          case (dec.grp)
            GRP_DIR:  dir_d[b*WORD_W +: WORD_W] = bus_wdata;
            GRP_SET:  lat_d[b*WORD_W +: WORD_W] = lat_q[b*WORD_W +: WORD_W] | bus_wdata;
            GRP_CLR:  lat_d[b*WORD_W +: WORD_W] = lat_q[b*WORD_W +: WORD_W] & ~bus_wdata;
            GRP_RISE: ren_d[b*WORD_W +: WORD_W] = bus_wdata;
            GRP_FALL: fen_d[b*WORD_W +: WORD_W] = bus_wdata;
            GRP_STAT: w1c[b*WORD_W +: WORD_W]   = bus_wdata;
            default: ;
          endcase
        end
      end
      for (int a = 0; a < ALT_WORDS; a++) begin
        if (dec.grp == GRP_ALT && dec.idx == IDX_W'(a))
          alt_d[a*WORD_W +: WORD_W] = bus_wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      lat_q <= '0;
      dir_q <= '0;
      ren_q <= '0;
      fen_q <= '0;
      alt_q <= '0;
    end else begin
      if (lat_en) lat_q <= lat_d;
      if (dir_en) dir_q <= dir_d;
      if (ren_en) ren_q <= ren_d;
      if (fen_en) fen_q <= fen_d;
      if (alt_en) alt_q <= alt_d;
    end
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    gpio_edge_bank #(.W(WORD_W)) u_edge (
      .clk     (clk),
      .rst_n   (rst_core_n),
      .rise    (rise[b*WORD_W +: WORD_W]),
      .fall    (fall[b*WORD_W +: WORD_W]),
      .rise_en (ren_q[b*WORD_W +: WORD_W]),
      .fall_en (fen_q[b*WORD_W +: WORD_W]),
      .w1c     (w1c[b*WORD_W +: WORD_W]),
      .status  (status[b*WORD_W +: WORD_W])
    );
  end

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (rd_hit) begin
      for (int b = 0; b < NBANK; b++) begin
        if (dec.idx == IDX_W'(b)) begin
          case (dec.grp)
            GRP_LEVEL: bus_rdata = level[b*WORD_W +: WORD_W];
            GRP_DIR:   bus_rdata = dir_q[b*WORD_W +: WORD_W];
            GRP_RISE:  bus_rdata = ren_q[b*WORD_W +: WORD_W];
            GRP_FALL:  bus_rdata = fen_q[b*WORD_W +: WORD_W];
            GRP_STAT:  bus_rdata = status[b*WORD_W +: WORD_W];
            default: ;
          endcase
        end
      end
      for (int a = 0; a < ALT_WORDS; a++) begin
        if (dec.grp == GRP_ALT && dec.idx == IDX_W'(a))
          bus_rdata = alt_q[a*WORD_W +: WORD_W];
      end
    end
  end

  assign pad_out  = lat_q;
  assign pad_oe   = dir_q;
  assign alt_func = alt_q;
  assign irq      = |status;
endmodule

// File: rtl/gpio_bank_ctrl_chk.sv
module gpio_bank_ctrl_chk #(
  parameter int NUM_PINS = 64,
  parameter int ADDR_W   = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  bus_sel,
  input logic                  bus_wr,
  input logic [ADDR_W-1:0]     bus_addr,
  input logic [31:0]           bus_wdata,
  input logic [31:0]           bus_rdata,
  input logic [NUM_PINS-1:0]   pad_out,
  input logic [NUM_PINS-1:0]   pad_oe,
  input logic [2*NUM_PINS-1:0] alt_func,
  input logic                  irq
);
  localparam int NB     = NUM_PINS / 32;
  localparam int SET0   = 2 * NB;
  localparam int CLR0   = 3 * NB;
  localparam int DIR0   = 1 * NB;
  localparam int STAT0  = 6 * NB;
  localparam int ALT0   = 7 * NB;
  localparam int TOP_W  = 9 * NB;
  localparam logic [NUM_PINS-1:0]   LOW_P = NUM_PINS'(32'hFFFF_FFFF);
  localparam logic [2*NUM_PINS-1:0] LOW_A = (2*NUM_PINS)'(32'hFFFF_FFFF);

  logic [1:0] age_q;
  logic       rdy, wr_ok;
  int         wa;
  logic [NUM_PINS-1:0]   wd_p;
  logic [2*NUM_PINS-1:0] wd_a;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              age_q <= '0;
    else if (age_q != 2'd3)  age_q <= age_q + 2'd1;
  end

  assign rdy   = (age_q == 2'd3);
  assign wa    = int'(bus_addr[ADDR_W-1:2]);
  assign wr_ok = bus_sel && bus_wr && (bus_addr[1:0] == 2'b00);
  assign wd_p  = NUM_PINS'(bus_wdata);
  assign wd_a  = (2*NUM_PINS)'(bus_wdata);

  // R2
  set_bank0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy && wr_ok && wa == SET0) |=> ((pad_out & $past(wd_p)) == $past(wd_p)));

  // R3
  clr_bank0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy && wr_ok && wa == CLR0) |=> ((pad_out & $past(wd_p)) == '0));

  // R4
  dir_bank0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy && wr_ok && wa == DIR0) |=> (((pad_oe ^ $past(wd_p)) & LOW_P) == '0));

  // R11
  alt_word0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy && wr_ok && wa == ALT0) |=> (((alt_func ^ $past(wd_a)) & LOW_A) == '0));

  // R8
  sticky_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy && irq && !(wr_ok && wa >= STAT0 && wa < STAT0 + NB)) |=> irq);

  // R12
  setclr_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && wa >= SET0 && wa < CLR0 + NB) |-> (bus_rdata == '0));

  // R1
  unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && wa >= TOP_W) |-> (bus_rdata == '0));
endmodule

bind gpio_bank_ctrl gpio_bank_ctrl_chk #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .pad_out   (pad_out),
  .pad_oe    (pad_oe),
  .alt_func  (alt_func),
  .irq       (irq)
);

// File: tb/gpio_bank_ctrl_test.sv
`timescale 1ns/1ps
module gpio_bank_ctrl_test;
  localparam int NP = 64;
  localparam int NB = NP / 32;
  localparam int AW = 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            bus_sel = 1'b0, bus_wr = 1'b0;
  logic [AW-1:0]   bus_addr = '0;
  logic [31:0]     bus_wdata = '0;
  logic [31:0]     bus_rdata;
  logic [NP-1:0]   pad_in = '0;
  logic [NP-1:0]   pad_out, pad_oe;
  logic [2*NP-1:0] alt_func;
  logic            irq;

  always #2.5 clk = ~clk;

  gpio_bank_ctrl #(.NUM_PINS(NP), .ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .alt_func(alt_func), .irq(irq)
  );

  int n_chk = 0;
  int n_fail = 0;

  // reference state
  bit [NP-1:0]   m_lat, m_dir, m_ren, m_fen, m_sts;
  bit [2*NP-1:0] m_alt;
  bit [NP-1:0]   hist[$];   // [older, synced, newest]
  logic [NP-1:0] pad_r = '0;

  function automatic logic [31:0] m_read(int a);
    int w = a / 4;
    int g, b;
    if ((a % 4) != 0 || w >= 9 * NB) return 32'h0;
    g = w / NB;
    b = w % NB;
    if (g >= 7) return m_alt[(w - 7*NB)*32 +: 32];
    case (g)
      0: return hist[1][b*32 +: 32];
      1: return m_dir[b*32 +: 32];
      4: return m_ren[b*32 +: 32];
      5: return m_fen[b*32 +: 32];
      6: return m_sts[b*32 +: 32];
      default: return 32'h0;
    endcase
  endfunction

  function automatic string rd_tag(int a);
    int w = a / 4;
    if (w >= 9 * NB) return "R1 unmapped read";
    case (w / NB)
      0: return "R5 level read";
      1: return "R4 direction read";
      2, 3: return "R12 set/clear read";
      4: return "R6 rise-enable read";
      5: return "R7 fall-enable read";
      6: return "R8 status read";
      default: return "R11 alt read";
    endcase
  endfunction

  task automatic check(string tag, logic [127:0] act, logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one clock: drive at negedge, compare, then advance the model at posedge
  task automatic cyc(bit sel, bit wr, int addr, logic [31:0] wd);
    bit [NP-1:0] ev, w1c;
    int w, g, b;
    @(negedge clk);
    bus_sel = sel; bus_wr = wr; bus_addr = AW'(addr); bus_wdata = wd; pad_in = pad_r;
    #1;
    check("R2 R3 pad_out", 128'(pad_out), 128'(m_lat));
    check("R4 pad_oe", 128'(pad_oe), 128'(m_dir));
    check("R11 alt_func", 128'(alt_func), 128'(m_alt));
    check("R10 irq", 128'(irq), 128'(|m_sts));
    if (sel && !wr) check(rd_tag(addr), 128'(bus_rdata), 128'(m_read(addr)));
    @(posedge clk);
    ev  = (hist[1] & ~hist[0] & m_ren) | (~hist[1] & hist[0] & m_fen);
    w1c = '0;
    w   = addr / 4;
    if (sel && wr && (addr % 4) == 0 && w < 9 * NB) begin
      g = w / NB; b = w % NB;
      case (g)
        1: m_dir[b*32 +: 32] = wd;
        2: m_lat[b*32 +: 32] = m_lat[b*32 +: 32] | wd;
        3: m_lat[b*32 +: 32] = m_lat[b*32 +: 32] & ~wd;
        4: m_ren[b*32 +: 32] = wd;
        5: m_fen[b*32 +: 32] = wd;
        6: w1c[b*32 +: 32] = wd;
        7, 8: m_alt[(w - 7*NB)*32 +: 32] = wd;
        default: ;
      endcase
    end
    m_sts = (m_sts & ~w1c) | ev;
    hist.push_back(pad_r);
    void'(hist.pop_front());
  endtask

  function automatic int wa(int g, int b);
    return (g * NB + b) * 4;
  endfunction

  task automatic wr(int a, logic [31:0] d); cyc(1'b1, 1'b1, a, d); endtask
  task automatic rd(int a);                 cyc(1'b1, 1'b0, a, 32'h0); endtask
  task automatic idle();                    cyc(1'b0, 1'b0, 0, 32'h0); endtask

  task automatic sweep();
    for (int a = 0; a < (9 * NB + 2) * 4; a += 4) rd(a);
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not complete");
    summary();
  end

  initial begin
    m_lat = '0; m_dir = '0; m_ren = '0; m_fen = '0; m_sts = '0; m_alt = '0;
    for (int i = 0; i < 3; i++) hist.push_back('0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R12: reset state
    #1;
    check("R12 reset pad_out", 128'(pad_out), 128'(0));
    check("R12 reset pad_oe", 128'(pad_oe), 128'(0));
    check("R12 reset alt_func", 128'(alt_func), 128'(0));
    check("R12 reset irq", 128'(irq), 128'(0));
    sweep();

    // R4, R2, R3
    wr(wa(1, 0), 32'h0000_FFFF);
    wr(wa(1, 1), 32'hF000_0001);
    wr(wa(2, 0), 32'h00FF_00FF);
    wr(wa(2, 1), 32'h8000_0001);
    wr(wa(3, 0), 32'h0000_00F0);
    wr(wa(2, 0), 32'h0);
    wr(wa(3, 1), 32'h0);
    idle();
    sweep();

    // R11
    for (int a = 0; a < 2 * NB; a++) wr(wa(7, 0) + 4 * a, 32'hA5C3_0000 ^ (32'h1111 * (a + 1)));
    idle();
    check("R11 pin17 code", 128'(alt_func[35:34]), 128'(m_alt[35:34]));

    // R1: unmapped, unaligned and level writes ignored
    wr((9 * NB) * 4, 32'hFFFF_FFFF);
    wr(wa(1, 0) + 1, 32'hDEAD_BEEF);
    wr(wa(0, 0), 32'hFFFF_FFFF);
    rd(wa(1, 0) + 1);
    sweep();

    // R5, R6, R7
    wr(wa(4, 0), 32'h0000_010F);
    wr(wa(5, 0), 32'h0000_01F0);
    wr(wa(4, 1), 32'h8000_0000);
    wr(wa(6, 0), 32'hFFFF_FFFF);
    pad_r = 64'h8000_0000_0000_01FF;
    idle(); idle(); idle();
    rd(wa(0, 0));
    rd(wa(6, 0));
    check("R6 rising capture", 128'(bus_rdata), 128'(32'h0000_010F));
    rd(wa(6, 1));
    pad_r = 64'h0;
    idle(); idle(); idle();
    rd(wa(6, 0));
    check("R7 falling capture", 128'(bus_rdata), 128'(32'h0000_01FF));

    // R8: partial and full clear
    wr(wa(6, 0), 32'h0000_000F);
    rd(wa(6, 0));
    check("R8 partial clear", 128'(bus_rdata), 128'(32'h0000_01F0));
    wr(wa(6, 0), 32'hFFFF_FFFF);
    wr(wa(6, 1), 32'hFFFF_FFFF);
    rd(wa(6, 0));
    check("R8 full clear", 128'(bus_rdata), 128'(32'h0));

    // R9: clear lands on the same edge as a new rising event on pin 0
    idle();
    pad_r = 64'h1;
    idle();
    idle();
    wr(wa(6, 0), 32'h0000_0001);
    rd(wa(6, 0));
    check("R9 edge wins over clear", 128'(bus_rdata[0]), 128'(1));
    wr(wa(6, 0), 32'h0000_0001);
    rd(wa(6, 0));
    check("R8 clear without edge", 128'(bus_rdata[0]), 128'(0));

    // mixed random traffic
    for (int i = 0; i < 600; i++) begin
      int op = int'($urandom % 5);
      int a  = int'($urandom % (9 * NB + 2)) * 4;
      pad_r = pad_r ^ ({$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom});
      case (op)
        0: idle();
        1, 2: rd(a);
        3: wr(a, $urandom);
        default: wr(wa(6, int'($urandom % NB)), 32'hFFFF_FFFF);
      endcase
    end
    sweep();
    summary();
  end
endmodule